// File: doc/BRIEF.md
# Return-clock aligned JTAG output launcher

This block drives the TMS and target-data pins of a JTAG pod. It times them from the test clock that the target sends back, not from the clock the pod generates, so that cable and buffer delays on the return path are tracked. The returned clock is synchronized into the system clock domain. Its rising edges, or its falling edges, are the launch edges. Bits from the JTAG controller are captured on launch edges and travel through a pipeline whose length is set in returned-clock cycles. Each pin then passes through its own fine delay of whole system clocks, so the two pins can be moved apart in time and their edges do not coincide.

When the target returns no clock, a bypass mode rebuilds the test clock level from the rise and fall pulses of the internal clock generator. That level passes through a short adjustable delay and then takes the place of the returned clock. Any change to the configuration empties the pipeline and forces both pins back to their idle level, so no stale bit reaches the target.

Top module: `jtag_return_launch`

## Requirements
- R1: After reset both pins, tms_o and tdo_o, sit at their idle level, which is 1 for each.
- R2: The bits presented on tms_bit_i/tdo_bit_i at launch edge k are driven on the pins after launch edge k+L-1. L is the effective link delay (3, 4 or 5). Until L launch edges have occurred since the last flush, the pins stay idle.
- R3: link_dly_i is a 3-bit field. The values 3, 4 and 5 select that link delay. Values below 3 behave as 3, and values above 5 behave as 5.
- R4: With fall_launch_i=0, launch edges are the rising transitions of the reference clock. Falling transitions leave the pins unchanged.
- R5: With fall_launch_i=1, launch edges are the falling transitions of the reference clock. Rising transitions leave the pins unchanged.
- R6: In return-clock mode (no_rclk_i=0), a pin whose fine field is F changes on the (4+F)-th system clock rising edge after the tckr_i transition that launches it. F ranges from 0 to 7.
- R7: tms_o uses only tms_fine_i and tdo_o uses only tdo_fine_i, so the two pins can change on different system clock edges for the same launch.
- R8: With no_rclk_i=1, tckr_i has no effect. The reference level is set by a one-cycle tck_rise_i pulse and cleared by a tck_fall_i pulse, then delayed by byp_dly_i (B, 0 to 3) clocks. A pin changes on the (3+B+F)-th clock edge, counting the edge that samples the pulse as the first.
- R9: When any configuration input changes, both pins return to idle on the next clock edge and the pipeline is emptied, so the rule in R2 starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tckr_i | input | 1 | Raw test clock returned by the target |
| tck_rise_i | input | 1 | One-cycle pulse: internal TCK rises |
| tck_fall_i | input | 1 | One-cycle pulse: internal TCK falls |
| tms_bit_i | input | 1 | Next TMS bit from the controller |
| tdo_bit_i | input | 1 | Next target-data bit from the controller |
| link_dly_i | input | 3 | Link delay in reference clock cycles |
| fall_launch_i | input | 1 | 1: launch on falling reference edges |
| no_rclk_i | input | 1 | 1: use the internal TCK bypass instead of tckr_i |
| byp_dly_i | input | 2 | Bypass delay in system clocks |
| tms_fine_i | input | 3 | TMS fine delay in system clocks |
| tdo_fine_i | input | 3 | Data-pin fine delay in system clocks |
| tms_o | output | 1 | TMS pin level |
| tdo_o | output | 1 | Data pin level toward the target |

## Verification
The bench measures latency to the exact system clock edge, using different fine values on the two pins. A tap mux that is off by one, or a fine field routed to the wrong pin, therefore shows up as a one-cycle error on one of them. Streams of distinct bits are run in both edge modes, checking after each transition. A design that launched on both edges, or captured on the wrong one, would drive a bit half a period early. The link field is driven to out-of-range values, and a missing clamp would give the wrong pipeline length or an idle output. Bypass mode is run with tckr_i toggling. Configuration changes are made mid-stream, and a design without a flush would keep driving old bits instead of idle.

// File: rtl/jtl_pkg.sv
package jtl_pkg;
  localparam int unsigned JTL_NSIG    = 2;
  localparam int unsigned JTL_SIG_TMS = 0;
  localparam int unsigned JTL_SIG_TDO = 1;
  localparam int unsigned JTL_LINK_W  = 3;
  localparam int unsigned JTL_BYP_W   = 2;
  localparam int unsigned JTL_FINE_W  = 3;

  typedef struct packed {
    logic [JTL_LINK_W-1:0] link;
    logic                  fall;
    logic                  no_rclk;
    logic [JTL_BYP_W-1:0]  byp;
    logic [JTL_FINE_W-1:0] fine_tms;
    logic [JTL_FINE_W-1:0] fine_tdo;
  } jtl_cfg_t;
endpackage

// File: rtl/jtl_ref_edge.sv
// Reference clock selection and launch-edge detection.
module jtl_ref_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYP_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tckr_i,
  input  logic             tck_rise_i,
  input  logic             tck_fall_i,
  input  logic             no_rclk_i,
  input  logic [BYP_W-1:0] byp_sel_i,
  input  logic             fall_sel_i,
  input  logic             flush_i,
  output logic             launch_o
);
  localparam int unsigned BYP_TAPS = 1 << BYP_W;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   tck_lvl_q;
  logic                   byp_q [BYP_TAPS-1];
  logic                   byp_ref;
  logic                   ref_lvl;
  logic                   prev_q;
  logic                   rise_w, fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], tckr_i};
  end

  // internal TCK level rebuilt from generator pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tck_lvl_q <= 1'b0;
    else if (tck_rise_i) tck_lvl_q <= 1'b1;
    else if (tck_fall_i) tck_lvl_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYP_TAPS-1; i++) byp_q[i] <= 1'b0;
    end else begin
      byp_q[0] <= tck_lvl_q;
      for (int i = 1; i < BYP_TAPS-1; i++) byp_q[i] <= byp_q[i-1];
    end
  end

  always_comb begin
    byp_ref = tck_lvl_q;
    for (int i = 1; i < BYP_TAPS; i++)
      if (byp_sel_i == BYP_W'(i)) byp_ref = byp_q[i-1];
  end

  assign ref_lvl = no_rclk_i ? byp_ref : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ref_lvl;
  end

  assign rise_w   = ref_lvl & ~prev_q;
  assign fall_w   = ~ref_lvl & prev_q;
  assign launch_o = ~flush_i & (fall_sel_i ? fall_w : rise_w);

  AST_LAUNCH_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o) else $error("launch edges too close"); // R4
endmodule

// File: rtl/jtl_link_pipe.sv
// Coarse link delay counted in launch edges.
module jtl_link_pipe #(
  parameter int unsigned NSIG     = 2,
  parameter int unsigned LINK_W   = 3,
  parameter int unsigned LINK_MIN = 3,
  parameter int unsigned LINK_MAX = 5,
  parameter logic [NSIG-1:0] IDLE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              flush_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [NSIG-1:0]   bits_i,
  output logic [NSIG-1:0]   coarse_o
);
  localparam int unsigned CNT_W  = $clog2(LINK_MAX+1);
  localparam int unsigned FLAT_W = NSIG*LINK_MAX;

  logic [NSIG-1:0]   pipe_q [LINK_MAX];
  logic [CNT_W-1:0]  prime_cnt_q;
  logic [LINK_W-1:0] link_eff;
  logic [FLAT_W-1:0] pipe_flat;

  always_comb begin
    if (link_i < LINK_W'(LINK_MIN))      link_eff = LINK_W'(LINK_MIN);
    else if (link_i > LINK_W'(LINK_MAX)) link_eff = LINK_W'(LINK_MAX);
    else                                 link_eff = link_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINK_MAX; i++) pipe_q[i] <= IDLE;
      prime_cnt_q <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < LINK_MAX; i++) pipe_q[i] <= IDLE;
      prime_cnt_q <= '0;
    end else if (launch_i) begin
      pipe_q[0] <= bits_i;
      for (int i = 1; i < LINK_MAX; i++) pipe_q[i] <= pipe_q[i-1];
      if (prime_cnt_q != CNT_W'(LINK_MAX)) prime_cnt_q <= prime_cnt_q + 1'b1;
    end
  end

  always_comb begin
    coarse_o = IDLE;
    for (int i = 0; i < LINK_MAX; i++)
      if (link_eff == LINK_W'(i+1)) coarse_o = pipe_q[i];
  end

  always_comb begin
    for (int i = 0; i < LINK_MAX; i++) pipe_flat[i*NSIG +: NSIG] = pipe_q[i];
  end

  AST_PIPE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (coarse_o == IDLE)) else $error("stale bit after flush"); // R9
  AST_PIPE_PRIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(prime_cnt_q) < int'(link_eff)) |-> (coarse_o == IDLE)) else $error("bit before link delay"); // R2
  AST_PIPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && !flush_i) |=> $stable(pipe_flat)) else $error("pipe moved without launch"); // R4
endmodule

// File: rtl/jtl_fine_dly.sv
// Per-signal fine skew: tap-selectable shift register (FINE_W >= 2).
module jtl_fine_dly #(
  parameter int unsigned FINE_W = 3,
  parameter bit          IDLE   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic [FINE_W-1:0] sel_i,
  input  logic              flush_i,
  output logic              dout_o
);
  localparam int unsigned TAPS = 1 << FINE_W;

  logic [TAPS-2:0] line_q;
  logic            tap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      line_q <= {(TAPS-1){IDLE}};
    else if (flush_i) line_q <= {(TAPS-1){IDLE}};
    else              line_q <= {line_q[TAPS-3:0], din_i};
  end

  always_comb begin
    tap_w = din_i;
    for (int i = 1; i < TAPS; i++)
      if (sel_i == FINE_W'(i)) tap_w = line_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dout_o <= IDLE;
    else if (flush_i) dout_o <= IDLE;
    else              dout_o <= tap_w;
  end

  AST_FINE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (dout_o == IDLE)) else $error("pin not idle after flush"); // R9
endmodule

// File: rtl/jtag_return_launch.sv
module jtag_return_launch
  import jtl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LINK_MIN    = 3,
  parameter int unsigned LINK_MAX    = 5,
  parameter bit          IDLE_TMS    = 1'b1,
  parameter bit          IDLE_TDO    = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tckr_i,
  input  logic                  tck_rise_i,
  input  logic                  tck_fall_i,
  input  logic                  tms_bit_i,
  input  logic                  tdo_bit_i,
  input  logic [JTL_LINK_W-1:0] link_dly_i,
  input  logic                  fall_launch_i,
  input  logic                  no_rclk_i,
  input  logic [JTL_BYP_W-1:0]  byp_dly_i,
  input  logic [JTL_FINE_W-1:0] tms_fine_i,
  input  logic [JTL_FINE_W-1:0] tdo_fine_i,
  output logic                  tms_o,
  output logic                  tdo_o
);
  localparam logic [JTL_NSIG-1:0] IDLE_VEC = {IDLE_TDO, IDLE_TMS};

  jtl_cfg_t              cfg_w, cfg_q;
  logic                  flush_w;
  logic                  launch_w;
  logic [JTL_NSIG-1:0]   bits_w;
  logic [JTL_NSIG-1:0]   coarse_w;
  logic [JTL_NSIG-1:0]   pin_w;
  logic [JTL_FINE_W-1:0] fine_sel [JTL_NSIG];

  assign cfg_w = '{link: link_dly_i, fall: fall_launch_i, no_rclk: no_rclk_i,
                   byp: byp_dly_i, fine_tms: tms_fine_i, fine_tdo: tdo_fine_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_w;
  end

  // any setting change drains stale bits
  assign flush_w = (cfg_w != cfg_q);

  assign bits_w[JTL_SIG_TMS]   = tms_bit_i;
  assign bits_w[JTL_SIG_TDO]   = tdo_bit_i;
  assign fine_sel[JTL_SIG_TMS] = tms_fine_i;
  assign fine_sel[JTL_SIG_TDO] = tdo_fine_i;

  jtl_ref_edge #(
    .SYNC_STAGES (SYNC_STAGES),
    .BYP_W       (JTL_BYP_W)
  ) i_ref_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tckr_i     (tckr_i),
    .tck_rise_i (tck_rise_i),
    .tck_fall_i (tck_fall_i),
    .no_rclk_i  (no_rclk_i),
    .byp_sel_i  (byp_dly_i),
    .fall_sel_i (fall_launch_i),
    .flush_i    (flush_w),
    .launch_o   (launch_w)
  );

  jtl_link_pipe #(
    .NSIG     (JTL_NSIG),
    .LINK_W   (JTL_LINK_W),
    .LINK_MIN (LINK_MIN),
    .LINK_MAX (LINK_MAX),
    .IDLE     (IDLE_VEC)
  ) i_link_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch_w),
    .flush_i  (flush_w),
    .link_i   (link_dly_i),
    .bits_i   (bits_w),
    .coarse_o (coarse_w)
  );

  for (genvar g = 0; g < JTL_NSIG; g++) begin : g_fine
    jtl_fine_dly #(
      .FINE_W (JTL_FINE_W),
      .IDLE   (IDLE_VEC[g])
    ) i_fine_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .din_i   (coarse_w[g]),
      .sel_i   (fine_sel[g]),
      .flush_i (flush_w),
      .dout_o  (pin_w[g])
    );
  end

  assign tms_o = pin_w[JTL_SIG_TMS];
  assign tdo_o = pin_w[JTL_SIG_TDO];
endmodule

// File: tb/test_jtag_return_launch.sv
module test_jtag_return_launch;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tckr = 1'b0, tck_rise = 1'b0, tck_fall = 1'b0;
  logic       tms_bit = 1'b0, tdo_bit = 1'b0;
  logic [2:0] link_dly = 3'd3;
  logic       fall_launch = 1'b0, no_rclk = 1'b0;
  logic [1:0] byp_dly = 2'd0;
  logic [2:0] tms_fine = 3'd0, tdo_fine = 3'd0;
  logic       tms_o, tdo_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  jtag_return_launch i_jtag_return_launch (
    .clk_i(clk), .rst_ni(rst_ni), .tckr_i(tckr), .tck_rise_i(tck_rise),
    .tck_fall_i(tck_fall), .tms_bit_i(tms_bit), .tdo_bit_i(tdo_bit),
    .link_dly_i(link_dly), .fall_launch_i(fall_launch), .no_rclk_i(no_rclk),
    .byp_dly_i(byp_dly), .tms_fine_i(tms_fine), .tdo_fine_i(tdo_fine),
    .tms_o(tms_o), .tdo_o(tdo_o)
  );

  task automatic check_pins(input string tag, input logic [1:0] exp);
    n_tests++;
    if ({tdo_o, tms_o} !== exp) begin
      n_fail++;
      $display("FAIL %s pins{tdo,tms} act=%b exp=%b t=%0t", tag, {tdo_o, tms_o}, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s latency act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [2:0] lk, input logic fl, input logic nr,
                           input logic [1:0] bp, input logic [2:0] ft, input logic [2:0] fd);
    @(negedge clk);
    tckr = 1'b0; link_dly = lk; fall_launch = fl; no_rclk = nr;
    byp_dly = bp; tms_fine = ft; tdo_fine = fd;
    repeat (5) @(negedge clk);
  endtask

  // one reference transition, then HALF clocks; bypass toggles tckr (must be ignored, R8)
  task automatic phase(input logic byp, input logic rise);
    if (byp) begin
      if (rise) tck_rise = 1'b1; else tck_fall = 1'b1;
      @(negedge clk);
      tck_rise = 1'b0; tck_fall = 1'b0;
      repeat (HALF-1) begin
        tckr = ~tckr;
        @(negedge clk);
      end
    end else begin
      tckr = rise;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic full_cycle(input logic byp);
    phase(byp, 1'b1);
    phase(byp, 1'b0);
  endtask

  // R2 data order under several link delays and edge modes
  task automatic run_stream(input string tag, input logic [2:0] lk, input int leff,
                            input logic fl, input logic byp);
    logic [7:0] ptms = 8'b0100_1101;
    logic [7:0] ptdo = 8'b1001_0110;
    apply_cfg(lk, fl, byp, byp ? 2'd1 : 2'd0, 3'd3, 3'd6);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] e_prev, e_now;
      int ip = k - leff;
      int in = k - leff + 1;
      e_prev = (ip >= 0) ? {ptdo[ip], ptms[ip]} : 2'b11;
      e_now  = (in >= 0) ? {ptdo[in], ptms[in]} : 2'b11;
      tms_bit = ptms[k];
      tdo_bit = ptdo[k];
      phase(byp, 1'b1);
      check_pins(tag, fl ? e_prev : e_now);
      phase(byp, 1'b0);
      check_pins(tag, e_now);
    end
  endtask

  // R6/R7/R8 exact edge of the pin change
  task automatic t_latency(input string tag, input logic byp, input logic [1:0] bp,
                           input logic [2:0] ft, input logic [2:0] fd);
    int lat_tms = 0;
    int lat_tdo = 0;
    int base = byp ? 3 + int'(bp) : 4;
    apply_cfg(3'd3, 1'b0, byp, bp, ft, fd);
    tms_bit = 1'b0; tdo_bit = 1'b0;
    repeat (3) full_cycle(byp);
    check_pins("R2", 2'b00);
    tms_bit = 1'b1; tdo_bit = 1'b1;
    repeat (2) full_cycle(byp);
    check_pins("R2", 2'b00);
    if (byp) tck_rise = 1'b1; else tckr = 1'b1;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk);
      #1;
      if (n == 1) tck_rise = 1'b0;
      if (tms_o && lat_tms == 0) lat_tms = n;
      if (tdo_o && lat_tdo == 0) lat_tdo = n;
    end
    check_int({tag, " tms"}, lat_tms, base + int'(ft));
    check_int(byp ? {tag, " tdo"} : "R7 tdo", lat_tdo, base + int'(fd));
    @(negedge clk);
    phase(byp, 1'b0);
  endtask

  // R9 configuration change flushes the pipeline
  task automatic t_flush();
    apply_cfg(3'd4, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0);
    tms_bit = 1'b0; tdo_bit = 1'b0;
    repeat (5) full_cycle(1'b0);
    check_pins("R2", 2'b00);
    @(negedge clk);
    tms_fine = 3'd1;
    @(posedge clk);
    #1;
    check_pins("R9", 2'b11);
    @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      full_cycle(1'b0);
      check_pins("R9", (k < 4) ? 2'b11 : 2'b00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_pins("R1", 2'b11);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_pins("R1", 2'b11);

    run_stream("R4", 3'd4, 4, 1'b0, 1'b0);
    run_stream("R5", 3'd5, 5, 1'b1, 1'b0);
    run_stream("R3 low", 3'd0, 3, 1'b0, 1'b0);
    run_stream("R3 high", 3'd7, 5, 1'b0, 1'b0);
    run_stream("R8 stream", 3'd3, 3, 1'b0, 1'b1);
    t_latency("R6", 1'b0, 2'd0, 3'd2, 3'd5);
    t_latency("R6", 1'b0, 2'd0, 3'd7, 3'd0);
    t_latency("R8", 1'b1, 2'd2, 3'd1, 3'd4);
    t_latency("R8", 1'b1, 2'd0, 3'd0, 3'd7);
    t_flush();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule